// File: doc/BRIEF.md
# Multi-Lane SPI Result Serializer

This block is the read-side output stage of a sampling converter's serial port. It holds the most recent 22-bit result and shifts it out, MSB first, while a host runs an SPI frame. Each launch event puts one, two or four bits on the output lanes. A shorter frame therefore moves the whole word: 22, 11 or 6 launch events. The protocol select picks the SCLK idle level and the capture edge. The lane-width and output-mode fields pick the lane count and an optional half-period early launch.

The block runs from a local clock `clk_i` that must be several times faster than SCLK. Chip select and SCLK pass through a synchronizer, and the edges are detected in the local domain. Each lane change follows the SCLK edge that causes it by `SYNC_STAGES + 1` local cycles. The host must sample later than that. The last result loaded by `result_load_i` is taken into the shift register when chip select falls. The protocol and the output fields are captured at that same moment. After the word has gone out, extra clocking gives zeros; nothing is passed through from another device. `rvs_o` shows whether a frame is in progress.

Top module: `mlane_result_ser`

## Requirements
- R1: The word goes out MSB first, right-padded with zeros to a multiple of four bits. Every launch after the last data group drives all lanes low.
- R2: Lane-width field encoding: 2'b00 gives one lane (the default) and 2'b01 also gives one lane. 2'b10 gives two lanes and 2'b11 gives four lanes. A lane outside the selected width is always low.
- R3: Lane order in two-lane mode: `sdo_o[1]` carries the earlier (higher) bit of each pair and `sdo_o[0]` the next one. In four-lane mode, `sdo_o[3]` carries the highest bit of each nibble, down to `sdo_o[0]` for the lowest.
- R4: Protocol select bit 1 is the SCLK idle level and bit 0 is the phase. With phase 0 (selects 00 and 10), the first group is driven once chip select falls. Capture is on the leading edge (rising for 00, falling for 10). The next group launches on the trailing edge.
- R5: With phase 1 (selects 01 and 11), all lanes stay low after chip select falls. The first leading edge (rising for 01, falling for 11) drives the first group, and each later leading edge drives the next one. Capture is on the trailing edge.
- R6: Output-mode field 2'b01 with phase 0 turns on early launch. Each group then advances on the capture (leading) edge, half an SCLK period earlier than standard.
- R7: Output-mode 2'b01 with phase 1 has no effect, and the frame behaves as in R5. Any other output-mode value selects standard timing.
- R8: While chip select is high, all lanes are low and SCLK edges are ignored. Each frame starts again from the MSB group.
- R9: The protocol, lane width, output mode and result word are sampled at chip select fall. Changing them, or loading a new result, in the middle of a frame does not change that frame.
- R10: `result_load_i` stores `result_i`. A frame with no new load sends the last stored word again.
- R11: `rvs_o` is low during the whole frame and high while chip select is high. It follows chip select `SYNC_STAGES + 1` cycles late.
- R12: During a frame, the lanes change only in response to a synchronized SCLK edge or a chip select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| result_i | input | DATA_W | Parallel result word |
| result_load_i | input | 1 | Stores `result_i` for the next frame |
| proto_sel_i | input | 2 | SCLK idle level (bit 1) and phase (bit 0) |
| sdo_width_i | input | 2 | Lane-width select |
| sdo_mode_i | input | 2 | Output mode; 2'b01 requests early launch |
| sdo_o | output | 4 | Serial output lanes |
| rvs_o | output | 1 | High when idle, low during a frame |

## Verification
A group pointer that is out of step shows as a lane pattern that differs from the expected group. In early-launch frames it also shows in the half-period after the capture edge. Either way it is visible within `SYNC_STAGES + 1` local cycles of the SCLK edge involved. A wrong launch-edge decode shifts the whole sequence by one half-period, so the first sample after chip select falls already differs. A stale lane-width or protocol latch shows as bits on lanes that should be low, or as word bits that appear at the wrong position. Failing to clear at chip select rise leaves non-zero lanes while the block is idle, and the next frame does not start at the MSB.

// File: rtl/mlser_pkg.sv
package mlser_pkg;
  localparam int unsigned LANES_MAX = 4;

  typedef enum logic [1:0] {
    LN_ONE  = 2'd0,
    LN_TWO  = 2'd1,
    LN_FOUR = 2'd2
  } lane_e;

  typedef struct packed {
    logic  cpol;
    logic  cpha;
    logic  early;
    lane_e lanes;
  } frame_cfg_t;

  function automatic lane_e decode_width(input logic [1:0] w);
    case (w)
      2'b10:   return LN_TWO;
      2'b11:   return LN_FOUR;
      default: return LN_ONE;
    endcase
  endfunction

  function automatic frame_cfg_t build_cfg(input logic [1:0] proto,
                                           input logic [1:0] width,
                                           input logic [1:0] mode);
    frame_cfg_t c;
    c.cpol  = proto[1];
    c.cpha  = proto[0];
    c.early = (mode == 2'b01) && !proto[0];  // early launch only for phase 0
    c.lanes = decode_width(width);
    return c;
  endfunction
endpackage

// File: rtl/mlser_edge_det.sv
module mlser_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic cs_s_o,
  output logic sclk_s_o,
  output logic cs_fall_o,
  output logic in_frame_o,
  output logic idle_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  logic cs_s, sclk_s;
  logic cs_q, sclk_q;

  if (SYNC_STAGES == 0) begin : g_nosync
    assign cs_s   = cs_ni;
    assign sclk_s = sclk_i;
  end else begin : g_sync
    logic [SYNC_STAGES-1:0] cs_sync, sclk_sync;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cs_sync   <= '1;
        sclk_sync <= '0;
      end else begin
        cs_sync[0]   <= cs_ni;
        sclk_sync[0] <= sclk_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
          cs_sync[k]   <= cs_sync[k-1];
          sclk_sync[k] <= sclk_sync[k-1];
        end
      end
    end
    assign cs_s   = cs_sync[SYNC_STAGES-1];
    assign sclk_s = sclk_sync[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign cs_s_o      = cs_s;
  assign sclk_s_o    = sclk_s;
  assign cs_fall_o   = cs_q & ~cs_s;
  assign in_frame_o  = ~cs_q & ~cs_s;
  assign idle_o      = cs_q;
  assign sclk_rise_o = sclk_s & ~sclk_q;
  assign sclk_fall_o = ~sclk_s & sclk_q;
endmodule

// File: rtl/mlser_launch_ctrl.sv
module mlser_launch_ctrl
  import mlser_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_fall_i,
  input  logic       in_frame_i,
  input  logic       sclk_rise_i,
  input  logic       sclk_fall_i,
  input  logic [1:0] proto_sel_i,
  input  logic [1:0] sdo_width_i,
  input  logic [1:0] sdo_mode_i,
  output frame_cfg_t cfg_o,
  output logic       start_active_o,
  output logic       advance_o
);
  frame_cfg_t cfg_d, cfg_q;
  logic lead_edge, trail_edge, adv_on_lead;

  assign cfg_d = build_cfg(proto_sel_i, sdo_width_i, sdo_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (cs_fall_i) cfg_q <= cfg_d;
  end

  // leading edge leaves the idle level, trailing edge returns to it
  assign lead_edge   = cfg_q.cpol ? sclk_fall_i : sclk_rise_i;
  assign trail_edge  = cfg_q.cpol ? sclk_rise_i : sclk_fall_i;
  assign adv_on_lead = cfg_q.cpha | cfg_q.early;

  assign advance_o      = in_frame_i & (adv_on_lead ? lead_edge : trail_edge);
  assign start_active_o = ~cfg_d.cpha;
  assign cfg_o          = cfg_q;
endmodule

// File: rtl/mlser_shifter.sv
module mlser_shifter
  import mlser_pkg::*;
#(
  parameter int unsigned DATA_W = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 load_i,
  input  logic [DATA_W-1:0]    word_i,
  input  logic                 start_active_i,
  input  logic                 advance_i,
  input  lane_e                lanes_i,
  output logic [LANES_MAX-1:0] sdo_o
);
  localparam int unsigned SH_W  = ((DATA_W + LANES_MAX - 1) / LANES_MAX) * LANES_MAX;
  localparam int unsigned PAD_W = SH_W - DATA_W;

  logic [SH_W-1:0] sh_q, sh_next;
  logic            active_q;

  always_comb begin
    case (lanes_i)
      LN_TWO:  sh_next = sh_q << 2;
      LN_FOUR: sh_next = sh_q << 4;
      default: sh_next = sh_q << 1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      active_q <= 1'b0;
    end else if (clear_i) begin
      active_q <= 1'b0;
    end else if (load_i) begin
      sh_q     <= SH_W'(word_i) << PAD_W;
      active_q <= start_active_i;
    end else if (advance_i) begin
      if (!active_q) active_q <= 1'b1;  // phase-1 first launch: no shift
      else           sh_q     <= sh_next;
    end
  end

  for (genvar j = 0; j < LANES_MAX; j++) begin : g_lane
    logic bit_one, bit_two, bit_four, bit_sel;
    if (j == 0) begin : g_one
      assign bit_one = sh_q[SH_W-1];
    end else begin : g_one_z
      assign bit_one = 1'b0;
    end
    if (j < 2) begin : g_two
      assign bit_two = sh_q[SH_W-2+j];
    end else begin : g_two_z
      assign bit_two = 1'b0;
    end
    assign bit_four = sh_q[SH_W-LANES_MAX+j];
    always_comb begin
      case (lanes_i)
        LN_TWO:  bit_sel = bit_two;
        LN_FOUR: bit_sel = bit_four;
        default: bit_sel = bit_one;
      endcase
    end
    assign sdo_o[j] = active_q & bit_sel;
  end
endmodule

// File: rtl/mlane_result_ser.sv
module mlane_result_ser
  import mlser_pkg::*;
#(
  parameter int unsigned DATA_W      = 22,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_load_i,
  input  logic [1:0]        proto_sel_i,
  input  logic [1:0]        sdo_width_i,
  input  logic [1:0]        sdo_mode_i,
  output logic [3:0]        sdo_o,
  output logic              rvs_o
);
  logic              cs_s, sclk_s, cs_fall, in_frame, idle;
  logic              sclk_rise, sclk_fall, advance, start_active;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] result_q, word_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            result_q <= '0;
    else if (result_load_i) result_q <= result_i;
  end

  assign word_sel = result_load_i ? result_i : result_q;

  mlser_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sclk_i      (sclk_i),
    .cs_s_o      (cs_s),
    .sclk_s_o    (sclk_s),
    .cs_fall_o   (cs_fall),
    .in_frame_o  (in_frame),
    .idle_o      (idle),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall)
  );

  mlser_launch_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cs_fall_i      (cs_fall),
    .in_frame_i     (in_frame),
    .sclk_rise_i    (sclk_rise),
    .sclk_fall_i    (sclk_fall),
    .proto_sel_i    (proto_sel_i),
    .sdo_width_i    (sdo_width_i),
    .sdo_mode_i     (sdo_mode_i),
    .cfg_o          (cfg_q),
    .start_active_o (start_active),
    .advance_o      (advance)
  );

  mlser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (cs_s),
    .load_i         (cs_fall),
    .word_i         (word_sel),
    .start_active_i (start_active),
    .advance_i      (advance),
    .lanes_i        (cfg_q.lanes),
    .sdo_o          (sdo_o)
  );

  assign rvs_o = idle;
endmodule

// File: rtl/mlser_checker.sv
module mlser_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s_i,
  input logic       sclk_s_i,
  input logic [3:0] sdo_i,
  input logic       rvs_i,
  input logic [1:0] lanes_i,
  input logic       cpha_i
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end
  logic warm;
  assign warm = (warm_q == 2'd3);

  // R2: unused lanes stay low
  assert_unused_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lanes_i == 2'd0) |-> (sdo_i[3:1] == 3'b000));
  assert_two_lane_upper_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lanes_i == 2'd1) |-> (sdo_i[3:2] == 2'b00));

  // R8: lanes low while chip select is idle
  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && cs_s_i && $past(cs_s_i)) |-> (sdo_i == 4'b0000));

  // R11: rvs low within a frame
  assert_rvs_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !cs_s_i && !$past(cs_s_i)) |-> !rvs_i);

  // R5: phase-1 frame starts with lanes low
  assert_phase1_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(cs_s_i, 2) && !$past(cs_s_i) && cpha_i) |-> (sdo_i == 4'b0000));

  // R12: no change without an SCLK edge inside a frame
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(cs_s_i) && !$past(cs_s_i, 2) && ($past(sclk_s_i) == $past(sclk_s_i, 2)))
      |-> $stable(sdo_i));
endmodule

bind mlane_result_ser mlser_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s_i   (cs_s),
  .sclk_s_i (sclk_s),
  .sdo_i    (sdo_o),
  .rvs_i    (rvs_o),
  .lanes_i  (cfg_q.lanes),
  .cpha_i   (cfg_q.cpha)
);

// File: tb/tb_mlane_result_ser.sv
module tb_mlane_result_ser;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [21:0] result = '0;
  logic        load = 1'b0;
  logic [1:0]  proto = 2'b00;
  logic [1:0]  width = 2'b00;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  sdo;
  logic        rvs;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlane_result_ser dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cs_ni         (cs_n),
    .sclk_i        (sclk),
    .result_i      (result),
    .result_load_i (load),
    .proto_sel_i   (proto),
    .sdo_width_i   (width),
    .sdo_mode_i    (mode),
    .sdo_o         (sdo),
    .rvs_o         (rvs)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] grp_val(input logic [21:0] word, input int w, input int k);
    logic [23:0] p;
    logic [3:0]  r;
    p = {word, 2'b00};
    r = '0;
    if (k < 0) return r;
    for (int j = 0; j < w; j++) begin
      int idx;
      idx = 23 - k*w - (w-1-j);
      if (idx >= 0) r[j] = p[idx];
    end
    return r;
  endfunction

  task automatic load_word(input logic [21:0] w);
    result = w;
    load   = 1'b1;
    tick(1);
    load   = 1'b0;
  endtask

  // one frame: expected values from the word and the mode rules
  task automatic run_frame(input string tag, input logic [1:0] p, input logic [1:0] wd,
                           input logic [1:0] md, input logic [21:0] word, input bit do_load,
                           input bit disturb, input logic [21:0] alt_word);
    int  w, grp;
    bit  cpha, cpol, edl;
    logic [3:0] e;
    w    = (wd == 2'b10) ? 2 : (wd == 2'b11) ? 4 : 1;
    grp  = (22 + w - 1) / w;
    cpha = p[0];
    cpol = p[1];
    edl  = (md == 2'b01) && !cpha;
    cs_n = 1'b1;
    proto = p; width = wd; mode = md;
    // SCLK activity while idle must be ignored (R8)
    for (int t = 0; t < 4; t++) begin
      sclk = ~sclk;
      tick(2);
    end
    sclk = cpol;
    tick(SETTLE);
    if (do_load) load_word(word);
    cs_n = 1'b0;
    tick(SETTLE);
    chk("R11 rvs in frame", {3'b000, rvs}, 4'h0);
    for (int i = 0; i < grp + 2; i++) begin
      if (disturb && i == 2) begin
        proto = ~p; width = ~wd; mode = ~md;
        load_word(alt_word);
        tick(SETTLE);
      end
      e = cpha ? grp_val(word, w, i - 1) : grp_val(word, w, i);
      chk(tag, sdo, e);
      if (i == 1) begin
        tick(10);
        chk("R12 hold", sdo, e);
      end
      sclk = ~cpol;
      tick(SETTLE);
      e = (cpha || edl) ? grp_val(word, w, i + (edl ? 1 : 0)) : grp_val(word, w, i);
      chk(tag, sdo, e);
      sclk = cpol;
      tick(SETTLE);
    end
    chk("R1 zero fill", sdo, 4'h0);
    cs_n = 1'b1;
    tick(SETTLE);
    chk("R8 idle lanes", sdo, 4'h0);
    chk("R11 rvs idle", {3'b000, rvs}, 4'h1);
  endtask

  task automatic t_reset;
    chk("R8 reset lanes", sdo, 4'h0);
    chk("R11 reset rvs", {3'b000, rvs}, 4'h1);
  endtask

  task automatic t_single;
    run_frame("R1 single 00", 2'b00, 2'b00, 2'b00, 22'h3A5C96, 1'b1, 1'b0, '0);
    run_frame("R2 width 01", 2'b00, 2'b01, 2'b00, 22'h1F0E2D, 1'b1, 1'b0, '0);
  endtask

  task automatic t_lanes;
    run_frame("R3 dual 10", 2'b10, 2'b10, 2'b00, 22'h2B7193, 1'b1, 1'b0, '0);
    run_frame("R4 quad 00", 2'b00, 2'b11, 2'b00, 22'h05ACE1, 1'b1, 1'b0, '0);
  endtask

  task automatic t_phase1;
    run_frame("R5 dual 01", 2'b01, 2'b10, 2'b00, 22'h3C0FF0, 1'b1, 1'b0, '0);
    run_frame("R5 quad 11", 2'b11, 2'b11, 2'b00, 22'h15AA5A, 1'b1, 1'b0, '0);
  endtask

  task automatic t_early;
    run_frame("R6 quad 00 early", 2'b00, 2'b11, 2'b01, 22'h2D4B87, 1'b1, 1'b0, '0);
    run_frame("R6 dual 10 early", 2'b10, 2'b10, 2'b01, 22'h1234AB, 1'b1, 1'b0, '0);
  endtask

  task automatic t_early_ignored;
    run_frame("R7 quad 11 mode01", 2'b11, 2'b11, 2'b01, 22'h3F00C3, 1'b1, 1'b0, '0);
    run_frame("R7 single 01 mode01", 2'b01, 2'b00, 2'b01, 22'h0A5F71, 1'b1, 1'b0, '0);
  endtask

  task automatic t_midframe;
    run_frame("R9 frozen cfg", 2'b00, 2'b10, 2'b00, 22'h2E6619, 1'b1, 1'b1, 22'h1B3D5E);
  endtask

  task automatic t_reuse;
    run_frame("R10 reuse word", 2'b10, 2'b11, 2'b00, 22'h1B3D5E, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(SETTLE);
    t_reset();
    t_single();
    t_lanes();
    t_phase1();
    t_early();
    t_early_ignored();
    t_midframe();
    t_reuse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule